// File: doc/BRIEF.md
# Region-Based Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for a paged machine whose address space is cut into regions. Pages are 512 bytes, so the low nine bits of an address are the byte offset and pass through unchanged. The 21 bits above the offset are the virtual page number. The two top bits pick the region: a user program region, a user stack region, a shared system region and a reserved encoding. Each usable region owns a linear page table, described by a base register and a length register.

A request carries the address, the privilege mode and the access direction. The block first checks the page number against the region's length. It then fetches page table entries over a single-outstanding memory read port and checks the entry's present bit and protection field. It finishes with a one-cycle done pulse that carries either a physical address or a fault code. The system table base is physical, so a system access needs one read. The two user table bases are virtual addresses in system space, so a user access first reads the system entry that maps its table page and then reads its own entry. A small write port loads the six base and length registers.

Top module: `vat_xlate`

## Requirements
- R1: A successful translation returns rsp_pa = {frame number of the final entry, virtual address bits 8:0}; the offset is never altered.
- R2: Address bits 31:30 select the region: 00 user program, 01 user stack, 10 system; 11 is reserved and completes with fault code 1 without any memory read.
- R3: A page number (bits 29:9) greater than or equal to the selected region's length register completes with fault code 2 and no memory read. Every faulting response drives rsp_pa to zero.
- R4: A system-region access makes exactly one read, at physical address system_base[29:0] + 4 × page number.
- R5: A user-region access forms the table address T = region_base + 4 × page number (32-bit). It reads the system entry at system_base[29:0] + 4 × T[29:9], then reads the user entry at {system entry frame, T[8:0]}: two reads in total.
- R6: Fault code 5 (table unreachable) is reported when T[31:30] is not 10 or T[29:9] is at or beyond the system length, with no read in either case. It is also reported, after one read, when the system entry's present bit is clear.
- R7: A page table entry uses bit 31 as present, bits 28:27 as protection and bits 20:0 as the frame number; a final entry with present clear completes with fault code 3, taking precedence over protection.
- R8: Protection 00 denies all access, 01 allows kernel only, 10 allows kernel any access and user reads, 11 allows all; a denied access completes with fault code 4. Fault code 0 means success.
- R9: req_ready is high only when idle and drops the cycle after a request is accepted. rsp_done is a single-cycle pulse. mem_req stays high with a stable mem_addr until mem_rvalid, and is low while idle. After reset req_ready=1, rsp_done=0 and mem_req=0.
- R10: When cfg_we is high, cfg_region (0 program, 1 stack, 2 system) and cfg_len (1 length, 0 base) pick the register that takes cfg_wdata. Requests accepted afterwards use the new value. All registers reset to zero, so every access in regions 0 to 2 first faults with code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_region | input | 2 | Region whose register is written |
| cfg_len | input | 1 | 1 writes the length register, 0 the base register |
| cfg_wdata | input | 32 | Value written |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept |
| req_va | input | 32 | Virtual address |
| req_kernel | input | 1 | 1 for kernel mode, 0 for user mode |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req | output | 1 | Memory read request, held until served |
| mem_addr | output | 30 | Physical byte address of the entry read |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Page table entry read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 3 | Fault code, 0 on success |
| rsp_pa | output | 30 | Physical address, zero on a fault |

## Verification
The bench sweeps page numbers in every region across the whole table, with dense coverage around length minus four to length plus three. A design with an off-by-one length compare would translate the first illegal page or reject the last legal one. Each page is tried in all four mode and direction combinations, and the memory model derives entries from their own addresses. A wrong table address, a swapped read order or a protection decode error therefore shows up as a wrong frame, a wrong read count or a wrong fault code. User tables that cross the end of the system table, and a user base moved out of system space, exercise the table-unreachable path. A design that skipped the system-length check there would read memory it must not touch.

// File: rtl/vat_pkg.sv
package vat_pkg;

   localparam int unsigned NUM_REGIONS = 3;
   localparam int unsigned SYS_IDX     = 2;

   typedef enum logic [2:0] {
      FLT_NONE = 3'd0,
      FLT_RSVD = 3'd1,
      FLT_LEN  = 3'd2,
      FLT_NOPG = 3'd3,
      FLT_PROT = 3'd4,
      FLT_TBL  = 3'd5
   } fault_e;

   typedef enum logic [1:0] {
      RG_PROG = 2'd0,
      RG_STAK = 2'd1,
      RG_SYS  = 2'd2,
      RG_RSVD = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVAL,
      ST_RD_SPTE,
      ST_RD_PTE
   } state_e;

endpackage

// File: rtl/vat_region_regs.sv
module vat_region_regs
   import vat_pkg::*;
#(
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LEN_W  = 22
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [1:0]                          cfg_region,
   input  logic                                cfg_len,
   input  logic [BASE_W-1:0]                   cfg_wdata,
   output logic [NUM_REGIONS-1:0][BASE_W-1:0]  base_o,
   output logic [NUM_REGIONS-1:0][LEN_W-1:0]   len_o
);

   if (LEN_W > BASE_W) begin : g_bad_len
      $error("vat_region_regs: LEN_W must not exceed BASE_W");
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      logic hit;
      assign hit = cfg_we && (cfg_region == 2'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            len_o[g]  <= '0;
         end else if (hit) begin
            if (cfg_len) begin
               len_o[g] <= cfg_wdata[LEN_W-1:0];
            end else begin
               base_o[g] <= cfg_wdata;
            end
         end
      end
   end

endmodule

// File: rtl/vat_addr_calc.sv
module vat_addr_calc
   import vat_pkg::*;
#(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned OFF_W   = 9,
   parameter int unsigned VPN_W   = 21,
   parameter int unsigned LEN_W   = 22,
   parameter int unsigned PA_W    = 30,
   parameter int unsigned PTE_LOG = 2
) (
   input  logic [1:0]                        region_i,
   input  logic [VPN_W-1:0]                  vpn_i,
   input  logic [NUM_REGIONS-1:0][VA_W-1:0]  base_i,
   input  logic [NUM_REGIONS-1:0][LEN_W-1:0] len_i,
   output fault_e                            rng_fault_o,
   output logic [PA_W-1:0]                   sys_pte_pa_o,
   output logic                              tbl_ok_o,
   output logic [PA_W-1:0]                   spte_pa_o,
   output logic [OFF_W-1:0]                  tva_off_o
);

   localparam int unsigned SCL_W = VPN_W + PTE_LOG;

   logic [1:0]        rg_idx;
   logic [SCL_W-1:0]  vpn_scaled;
   logic [PA_W-1:0]   sys_base_pa;
   logic [VA_W-1:0]   tva;
   logic [1:0]        tva_rg;
   logic [VPN_W-1:0]  tva_vpn;
   logic [SCL_W-1:0]  tva_scaled;
   logic              unused_base_hi;

   assign rg_idx = (region_i == RG_RSVD) ? 2'd0 : region_i;

   always_comb begin
      if (region_i == RG_RSVD) begin
         rng_fault_o = FLT_RSVD;
      end else if ({1'b0, vpn_i} >= len_i[rg_idx]) begin
         rng_fault_o = FLT_LEN;
      end else begin
         rng_fault_o = FLT_NONE;
      end
   end

   assign vpn_scaled     = {vpn_i, {PTE_LOG{1'b0}}};
   assign sys_base_pa    = base_i[SYS_IDX][PA_W-1:0];
   assign unused_base_hi = ^base_i[SYS_IDX][VA_W-1:PA_W];

   assign sys_pte_pa_o = sys_base_pa + PA_W'(vpn_scaled);

   assign tva        = base_i[rg_idx] + VA_W'(vpn_scaled);
   assign tva_rg     = tva[VA_W-1 -: 2];
   assign tva_vpn    = tva[OFF_W +: VPN_W];
   assign tva_off_o  = tva[OFF_W-1:0];
   assign tva_scaled = {tva_vpn, {PTE_LOG{1'b0}}};

   assign tbl_ok_o  = (tva_rg == RG_SYS) && ({1'b0, tva_vpn} < len_i[SYS_IDX]);
   assign spte_pa_o = sys_base_pa + PA_W'(tva_scaled);

endmodule

// File: rtl/vat_prot_check.sv
module vat_prot_check #(
   parameter int unsigned PTE_W    = 32,
   parameter int unsigned PFN_W    = 21,
   parameter int unsigned V_BIT    = 31,
   parameter int unsigned PROT_LSB = 27
) (
   input  logic [PTE_W-1:0] pte_i,
   input  logic             kernel_i,
   input  logic             write_i,
   output logic             present_o,
   output logic             allow_o,
   output logic [PFN_W-1:0] pfn_o
);

   logic [1:0] prot;
   logic       unused_pte;

   assign present_o  = pte_i[V_BIT];
   assign prot       = pte_i[PROT_LSB +: 2];
   assign pfn_o      = pte_i[PFN_W-1:0];
   assign unused_pte = ^pte_i;

   always_comb begin
      unique case (prot)
         2'b00:   allow_o = 1'b0;
         2'b01:   allow_o = kernel_i;
         2'b10:   allow_o = kernel_i || !write_i;
         default: allow_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
   import vat_pkg::*;
#(
   parameter int unsigned VA_W         = 32,
   parameter int unsigned OFF_W        = 9,
   parameter int unsigned PTE_W        = 32,
   parameter int unsigned PTE_V_BIT    = 31,
   parameter int unsigned PTE_PROT_LSB = 27,
   localparam int unsigned RSEL_W      = 2,
   localparam int unsigned VPN_W       = VA_W - RSEL_W - OFF_W,
   localparam int unsigned PFN_W       = VPN_W,
   localparam int unsigned PA_W        = PFN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_region,
   input  logic             cfg_len,
   input  logic [VA_W-1:0]  cfg_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_kernel,
   input  logic             req_write,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_rvalid,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic             rsp_done,
   output logic [2:0]       rsp_fault,
   output logic [PA_W-1:0]  rsp_pa
);

   localparam int unsigned LEN_W   = VPN_W + 1;
   localparam int unsigned PTE_LOG = $clog2(PTE_W / 8);

   if (PTE_W % 8 != 0) begin : g_bad_pte_bytes
      $error("vat_xlate: PTE_W must be a whole number of bytes");
   end
   if (PTE_V_BIT >= PTE_W || PTE_PROT_LSB + 2 > PTE_V_BIT) begin : g_bad_fields
      $error("vat_xlate: present or protection field misplaced");
   end
   if (PFN_W > PTE_PROT_LSB) begin : g_bad_pfn
      $error("vat_xlate: frame field overlaps protection field");
   end
   if (OFF_W < PTE_LOG || VPN_W < 2) begin : g_bad_split
      $error("vat_xlate: address split too narrow");
   end

   state_e                          state;
   logic [VA_W-1:0]                 va_q;
   logic                            kern_q;
   logic                            wr_q;
   logic [OFF_W-1:0]                tva_off_q;

   logic [NUM_REGIONS-1:0][VA_W-1:0]  reg_base;
   logic [NUM_REGIONS-1:0][LEN_W-1:0] reg_len;

   logic [1:0]        va_region;
   logic [VPN_W-1:0]  va_vpn;
   fault_e            rng_fault;
   logic [PA_W-1:0]   sys_pte_pa;
   logic              tbl_ok;
   logic [PA_W-1:0]   spte_pa;
   logic [OFF_W-1:0]  tva_off;

   logic              pte_present;
   logic              pte_allow;
   logic [PFN_W-1:0]  pte_pfn;

   assign va_region = va_q[VA_W-1 -: RSEL_W];
   assign va_vpn    = va_q[OFF_W +: VPN_W];
   assign req_ready = (state == ST_IDLE);

   vat_region_regs #(
      .BASE_W (VA_W),
      .LEN_W  (LEN_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_region (cfg_region),
      .cfg_len    (cfg_len),
      .cfg_wdata  (cfg_wdata),
      .base_o     (reg_base),
      .len_o      (reg_len)
   );

   vat_addr_calc #(
      .VA_W    (VA_W),
      .OFF_W   (OFF_W),
      .VPN_W   (VPN_W),
      .LEN_W   (LEN_W),
      .PA_W    (PA_W),
      .PTE_LOG (PTE_LOG)
   ) u_calc (
      .region_i     (va_region),
      .vpn_i        (va_vpn),
      .base_i       (reg_base),
      .len_i        (reg_len),
      .rng_fault_o  (rng_fault),
      .sys_pte_pa_o (sys_pte_pa),
      .tbl_ok_o     (tbl_ok),
      .spte_pa_o    (spte_pa),
      .tva_off_o    (tva_off)
   );

   vat_prot_check #(
      .PTE_W    (PTE_W),
      .PFN_W    (PFN_W),
      .V_BIT    (PTE_V_BIT),
      .PROT_LSB (PTE_PROT_LSB)
   ) u_prot (
      .pte_i     (mem_rdata),
      .kernel_i  (kern_q),
      .write_i   (wr_q),
      .present_o (pte_present),
      .allow_o   (pte_allow),
      .pfn_o     (pte_pfn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         va_q      <= '0;
         kern_q    <= 1'b0;
         wr_q      <= 1'b0;
         tva_off_q <= '0;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         rsp_done  <= 1'b0;
         rsp_fault <= FLT_NONE;
         rsp_pa    <= '0;
      end else begin
         rsp_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  kern_q <= req_kernel;
                  wr_q   <= req_write;
                  state  <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (rng_fault != FLT_NONE) begin
                  rsp_done  <= 1'b1;
                  rsp_fault <= rng_fault;
                  rsp_pa    <= '0;
                  state     <= ST_IDLE;
               end else if (va_region == RG_SYS) begin
                  mem_req  <= 1'b1;
                  mem_addr <= sys_pte_pa;
                  state    <= ST_RD_PTE;
               end else if (!tbl_ok) begin
                  rsp_done  <= 1'b1;
                  rsp_fault <= FLT_TBL;
                  rsp_pa    <= '0;
                  state     <= ST_IDLE;
               end else begin
                  mem_req   <= 1'b1;
                  mem_addr  <= spte_pa;
                  tva_off_q <= tva_off;
                  state     <= ST_RD_SPTE;
               end
            end
            ST_RD_SPTE: begin
               if (mem_rvalid) begin
                  if (!pte_present) begin
                     mem_req   <= 1'b0;
                     rsp_done  <= 1'b1;
                     rsp_fault <= FLT_TBL;
                     rsp_pa    <= '0;
                     state     <= ST_IDLE;
                  end else begin
                     mem_addr <= {pte_pfn, tva_off_q};
                     state    <= ST_RD_PTE;
                  end
               end
            end
            ST_RD_PTE: begin
               if (mem_rvalid) begin
                  mem_req  <= 1'b0;
                  rsp_done <= 1'b1;
                  state    <= ST_IDLE;
                  if (!pte_present) begin
                     rsp_fault <= FLT_NOPG;
                     rsp_pa    <= '0;
                  end else if (!pte_allow) begin
                     rsp_fault <= FLT_PROT;
                     rsp_pa    <= '0;
                  end else begin
                     rsp_fault <= FLT_NONE;
                     rsp_pa    <= {pte_pfn, va_q[OFF_W-1:0]};
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vat_xlate_chk.sv
module vat_xlate_chk #(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned OFF_W = 9,
   parameter int unsigned PA_W  = 30
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_va,
   input logic            mem_req,
   input logic [PA_W-1:0] mem_addr,
   input logic            mem_rvalid,
   input logic            rsp_done,
   input logic [2:0]      rsp_fault,
   input logic [PA_W-1:0] rsp_pa
);

   logic [VA_W-1:0] va_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_seen <= '0;
      end else if (req_valid && req_ready) begin
         va_seen <= req_va;
      end
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R9

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R9

   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req); // R9

   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_fault != 3'd0) |-> (rsp_pa == '0)); // R3

   AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && va_seen[VA_W-1 -: 2] == 2'b11) |-> (rsp_fault == 3'd1)); // R2

   AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_fault == 3'd0) |-> (rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0])); // R1

   AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_fault <= 3'd5)); // R8

endmodule

bind vat_xlate vat_xlate_chk #(
   .VA_W  (VA_W),
   .OFF_W (OFF_W),
   .PA_W  (PA_W)
) u_chk (.*);

// File: tb/vat_xlate_bench.sv
module vat_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_region = '0;
   logic        cfg_len = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_kernel = 1'b0;
   logic        req_write = 1'b0;
   logic        mem_req;
   logic [29:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_done;
   logic [2:0]  rsp_fault;
   logic [29:0] rsp_pa;

   int checks = 0;
   int errors = 0;
   int reads  = 0;
   int lat_cnt = 0;
   int lat_seed = 0;
   bit finished = 1'b0;

   logic [31:0] m_base [3];
   logic [31:0] m_len  [3];

   always #2 clk = ~clk;

   vat_xlate u_vat_xlate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_region (cfg_region),
      .cfg_len    (cfg_len),
      .cfg_wdata  (cfg_wdata),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_va     (req_va),
      .req_kernel (req_kernel),
      .req_write  (req_write),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .rsp_done   (rsp_done),
      .rsp_fault  (rsp_fault),
      .rsp_pa     (rsp_pa)
   );

   function automatic logic [31:0] pte_of(input logic [29:0] a);
      logic        v;
      logic [20:0] pfn;
      v   = (a[6:2] != 5'd7);
      pfn = a[28:8] ^ 21'h0A5A5;
      return {v, 2'b00, a[8:7], 6'd0, pfn};
   endfunction

   // memory model: answers each read after 0 to 2 idle cycles
   always @(negedge clk) begin
      if (mem_rvalid) begin
         mem_rvalid <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= pte_of(mem_addr);
            reads      <= reads + 1;
            lat_seed   <= lat_seed + 1;
            lat_cnt    <= (lat_seed * 7) % 3;
         end else begin
            lat_cnt <= lat_cnt - 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int rg, input bit is_len, input logic [31:0] d);
      @(negedge clk);
      cfg_we     = 1'b1;
      cfg_region = 2'(rg);
      cfg_len    = is_len;
      cfg_wdata  = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (rg < 3) begin
         if (is_len) m_len[rg] = {10'd0, d[21:0]};
         else        m_base[rg] = d;
      end
   endtask

   task automatic model(input logic [31:0] va, input bit kern, input bit wr,
                        output logic [2:0] f, output logic [29:0] pa, output int nrd);
      logic [1:0]  rg;
      logic [20:0] vpn;
      logic [31:0] t;
      logic [31:0] w;
      logic [29:0] a;
      bit          ok;
      rg  = va[31:30];
      vpn = va[29:9];
      f   = 3'd0;
      pa  = '0;
      nrd = 0;
      if (rg == 2'b11) begin
         f = 3'd1;
         return;
      end
      if ({11'd0, vpn} >= m_len[rg]) begin
         f = 3'd2;
         return;
      end
      if (rg == 2'b10) begin
         a = m_base[2][29:0] + {7'd0, vpn, 2'b00};
      end else begin
         t = m_base[rg] + {9'd0, vpn, 2'b00};
         if (t[31:30] != 2'b10 || {11'd0, t[29:9]} >= m_len[2]) begin
            f = 3'd5;
            return;
         end
         a   = m_base[2][29:0] + {7'd0, t[29:9], 2'b00};
         w   = pte_of(a);
         nrd = 1;
         if (!w[31]) begin
            f = 3'd5;
            return;
         end
         a = {w[20:0], t[8:0]};
      end
      w   = pte_of(a);
      nrd = nrd + 1;
      if (!w[31]) begin
         f = 3'd3;
         return;
      end
      case (w[28:27])
         2'b00:   ok = 1'b0;
         2'b01:   ok = kern;
         2'b10:   ok = kern || !wr;
         default: ok = 1'b1;
      endcase
      if (!ok) begin
         f = 3'd4;
         return;
      end
      pa = {w[20:0], va[8:0]};
   endtask

   task automatic xlate(input logic [31:0] va, input bit kern, input bit wr);
      logic [2:0]  ef;
      logic [29:0] epa;
      int          enr;
      int          r0;
      int          wait_cyc;
      string       tag;
      model(va, kern, wr, ef, epa, enr);
      case (ef)
         3'd1: tag = "R2";
         3'd2: tag = "R3";
         3'd3: tag = "R7";
         3'd4: tag = "R8";
         3'd5: tag = "R6";
         default: tag = (va[31:30] == 2'b10) ? "R4" : "R5";
      endcase
      @(negedge clk);
      r0         = reads;
      req_valid  = 1'b1;
      req_va     = va;
      req_kernel = kern;
      req_write  = wr;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
      wait_cyc = 0;
      while (!rsp_done && wait_cyc < 60) begin
         @(negedge clk);
         wait_cyc++;
      end
      if (!rsp_done) begin
         checks++;
         errors++;
         $display("FAIL R9: no done pulse for va %h, actual 0 expected 1", va);
         return;
      end
      check({tag, " fault code"}, {29'd0, rsp_fault}, {29'd0, ef});
      check("R1 physical address", {2'd0, rsp_pa}, {2'd0, epa});
      check({tag, " read count"}, reads - r0, enr);
      @(negedge clk);
      check("R9 done is one cycle", {31'd0, rsp_done}, 32'd0);
   endtask

   task automatic sweep(input int rg);
      int L;
      L = (rg == 3) ? 64 : int'(m_len[rg]);
      for (int i = 0; i < 48; i++) begin
         int vpn;
         if (i < 40) vpn = (i * (L + 8)) / 40;
         else        vpn = L - 4 + (i - 40);
         if (vpn < 0) vpn = 0;
         for (int c = 0; c < 4; c++) begin
            logic [31:0] va;
            int off;
            off = (i * 53 + c * 7) % 512;
            va  = {2'(rg), 21'(vpn), 9'(off)};
            xlate(va, c[0], c[1]);
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         m_base[k] = '0;
         m_len[k]  = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset ready", {31'd0, req_ready}, 32'd1);
      check("R9 reset done", {31'd0, rsp_done}, 32'd0);
      check("R9 reset mem_req", {31'd0, mem_req}, 32'd0);

      // R10: all lengths reset to zero
      xlate(32'h0000_0000, 1'b1, 1'b0);
      xlate(32'h8000_1234, 1'b1, 1'b0);
      xlate(32'h4000_0200, 1'b0, 1'b1);

      cfg_write(2, 1'b0, 32'h0020_0000);
      cfg_write(2, 1'b1, 32'd64);
      cfg_write(0, 1'b0, 32'h8000_0000);
      cfg_write(0, 1'b1, 32'h0000_1000);
      cfg_write(1, 1'b0, 32'h8000_6000);
      cfg_write(1, 1'b1, 32'h0000_1400);

      for (int rg = 0; rg < 4; rg++) sweep(rg);

      // R10: new stack base lies outside system space, so R6 table fault
      cfg_write(1, 1'b0, 32'h0000_1000);
      sweep(1);

      // R10: shrink the system length, both user and system regions react
      cfg_write(2, 1'b1, 32'd20);
      sweep(2);
      sweep(0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule